// File: doc/BRIEF.md
# Transmit Frame Queue

This block buffers outgoing frames between a host and a MAC transmitter. The host writes frame payload as 32-bit words into a deep data FIFO. Once every word of a frame is in, it writes one command word into a separate command FIFO. The command word holds the frame's byte count and the byte lane where the first valid byte sits. A frame can therefore start at any lane of its first word. The host reads the data FIFO occupancy before writing a frame, and two threshold flags give a coarse view of that fill level.

On the MAC side a two-state machine handles one frame at a time. In `ST_IDLE` it waits for a command. It pops the command and moves to `ST_STREAM`, unless the length is zero, in which case it discards the command and its words and stays in `ST_IDLE`. In `ST_STREAM` it presents one byte per accepted cycle, with start and end markers. It returns to `ST_IDLE` after the last byte and raises a one-cycle sent pulse. A flush input clears both FIFOs and forces `ST_IDLE` from either state.

Top module: `txq_top`

## Requirements
- R1: After reset, word_count is 0, almost_empty is 1, almost_full is 0, cmd_full is 0, mac_valid is 0 and pkt_sent is 0.
- R2: word_count equals data words written minus data words consumed. A data write while word_count equals DATA_DEPTH is ignored.
- R3: almost_full is 1 exactly when word_count >= DATA_DEPTH - AF_MARGIN (default 1664).
- R4: almost_empty is 1 exactly when word_count <= AE_LEVEL (default 384).
- R5: mac_valid stays 0 while no command is queued, whatever data words are present.
- R6: In a command word, bits 15:0 give the length in bytes and bits 17:16 give the start lane. Lane k of a data word is bits 8k+7:8k. Exactly length bytes are presented, in increasing lane order, starting at the start lane of the first word and continuing from lane 0 of each following word.
- R7: mac_sof is 1 on the first byte of a frame and mac_eof is 1 on its last byte. A one-byte frame carries both.
- R8: A frame consumes exactly floor((length + lane + 3) / 4) data words, and the next frame starts on a fresh word.
- R9: pkt_sent is 1 for exactly one cycle, the cycle after the last byte is accepted, and at no other time.
- R10: While mac_valid is 1 and mac_ready is 0, mac_byte, mac_sof and mac_eof hold their values.
- R11: A command with length 0 produces no byte and no pkt_sent. It consumes floor((lane + 3) / 4) data words.
- R12: A flush empties both FIFOs and abandons any frame in progress, so word_count is 0 and mac_valid is 0 on the next cycle. A data write in the flush cycle is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Clear both FIFOs and abandon the current frame |
| wr_data_valid | input | 1 | Write one data word |
| wr_data | input | 32 | Data word, lane k in bits 8k+7:8k |
| wr_cmd_valid | input | 1 | Write one command word |
| wr_cmd | input | 18 | Command: [15:0] byte length, [17:16] start lane |
| word_count | output | $clog2(DATA_DEPTH)+1 | Occupied data FIFO words |
| almost_full | output | 1 | Fill level at or above the upper threshold |
| almost_empty | output | 1 | Fill level at or below the lower threshold |
| cmd_full | output | 1 | Command FIFO has no free entry |
| mac_ready | input | 1 | MAC accepts the presented byte |
| mac_valid | output | 1 | A byte is presented |
| mac_byte | output | 8 | Presented byte |
| mac_sof | output | 1 | Presented byte is the first of its frame |
| mac_eof | output | 1 | Presented byte is the last of its frame |
| pkt_sent | output | 1 | One-cycle pulse after a frame's last byte is accepted |

## Verification
The bench builds the block with DATA_DEPTH=32, CMD_DEPTH=4, AF_MARGIN=8 and AE_LEVEL=8. With these values the full boundary, both flag thresholds (24 and 8 words) and the ignored write past full each take only a few dozen writes to reach. Frames of 1 to 13 bytes at every start lane cover single-word frames, frames that cross word boundaries and zero-length commands, all within a few hundred cycles.

// File: rtl/txq_pkg.sv
package txq_pkg;
    localparam int LEN_W  = 16;
    localparam int LANE_W = 2;
    localparam int CMD_W  = LEN_W + LANE_W;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_STREAM = 1'b1
    } txq_state_e;

    typedef struct packed {
        logic [LANE_W-1:0] lane;
        logic [LEN_W-1:0]  len;
    } txq_cmd_t;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 2048
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     push,
    input  logic [WIDTH-1:0]         din,
    input  logic                     pop,
    output logic [WIDTH-1:0]         dout,
    output logic [$clog2(DEPTH):0]   count,
    output logic                     empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             full, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_full_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/txq_unpacker.sv
module txq_unpacker
    import txq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              cmd_avail,
    input  txq_cmd_t          cmd,
    input  logic              word_avail,
    input  logic [31:0]       word,
    input  logic              mac_ready,
    output logic              cmd_pop,
    output logic              word_pop,
    output logic              mac_valid,
    output logic [7:0]        mac_byte,
    output logic              mac_sof,
    output logic              mac_eof,
    output logic              pkt_sent
);
    txq_state_e         state, state_nx;
    logic [LEN_W-1:0]   remain;
    logic [LANE_W-1:0]  lane;
    logic               first;
    logic               take, load;

    assign take = mac_valid && mac_ready;

    // State register and frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            remain   <= '0;
            lane     <= '0;
            first    <= 1'b0;
            pkt_sent <= 1'b0;
        end else if (flush) begin
            state    <= ST_IDLE;
            pkt_sent <= 1'b0;
        end else begin
            state    <= state_nx;
            pkt_sent <= take && mac_eof;
            if (load) begin
                remain <= cmd.len;
                lane   <= cmd.lane;
                first  <= 1'b1;
            end else if (take) begin
                remain <= remain - 1'b1;
                lane   <= lane + 1'b1;
                first  <= 1'b0;
            end
        end
    end

    // Outputs and next state
    always_comb begin
        state_nx  = state;
        cmd_pop   = 1'b0;
        word_pop  = 1'b0;
        load      = 1'b0;
        mac_valid = 1'b0;
        mac_sof   = 1'b0;
        mac_eof   = 1'b0;
        unique case (lane)
            2'd0: mac_byte = word[7:0];
            2'd1: mac_byte = word[15:8];
            2'd2: mac_byte = word[23:16];
            default: mac_byte = word[31:24];
        endcase
        unique case (state)
            ST_IDLE: begin
                if (cmd_avail) begin
                    cmd_pop = 1'b1;
                    if (cmd.len == '0) begin
                        word_pop = (cmd.lane != '0);
                    end else begin
                        load     = 1'b1;
                        state_nx = ST_STREAM;
                    end
                end
            end
            ST_STREAM: begin
                mac_valid = word_avail;
                mac_sof   = first;
                mac_eof   = (remain == LEN_W'(1));
                if (take) begin
                    word_pop = mac_eof || (lane == 2'd3);
                    if (mac_eof) state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assert_sent_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && mac_eof && !flush) |=> pkt_sent);
    assert_sent_only_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_sent |-> $past(take && mac_eof));
    assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_valid && !mac_ready && !flush) |=>
            (mac_valid && $stable(mac_byte) && $stable(mac_sof) && $stable(mac_eof)));
    assert_idle_without_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !cmd_avail) |=> !mac_valid);
endmodule

// File: rtl/txq_top.sv
module txq_top
    import txq_pkg::*;
#(
    parameter int DATA_DEPTH = 2048,
    parameter int CMD_DEPTH  = 16,
    parameter int AF_MARGIN  = 384,
    parameter int AE_LEVEL   = 384
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         wr_data_valid,
    input  logic [31:0]                  wr_data,
    input  logic                         wr_cmd_valid,
    input  logic [CMD_W-1:0]             wr_cmd,
    output logic [$clog2(DATA_DEPTH):0]  word_count,
    output logic                         almost_full,
    output logic                         almost_empty,
    output logic                         cmd_full,
    input  logic                         mac_ready,
    output logic                         mac_valid,
    output logic [7:0]                   mac_byte,
    output logic                         mac_sof,
    output logic                         mac_eof,
    output logic                         pkt_sent
);
    localparam int WCW = $clog2(DATA_DEPTH) + 1;
    localparam int CCW = $clog2(CMD_DEPTH) + 1;

    logic [31:0]      word;
    logic             data_empty, cmd_empty, cmd_pop, word_pop;
    logic [CMD_W-1:0] cmd_raw;
    logic [CCW-1:0]   cmd_count;
    txq_cmd_t         cmd;

    txq_fifo #(.WIDTH(32), .DEPTH(DATA_DEPTH)) u_data_fifo (
        .clk(clk), .rst_n(rst_n), .clr(flush),
        .push(wr_data_valid), .din(wr_data), .pop(word_pop),
        .dout(word), .count(word_count), .empty(data_empty)
    );

    txq_fifo #(.WIDTH(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
        .clk(clk), .rst_n(rst_n), .clr(flush),
        .push(wr_cmd_valid), .din(wr_cmd), .pop(cmd_pop),
        .dout(cmd_raw), .count(cmd_count), .empty(cmd_empty)
    );

    assign cmd          = txq_cmd_t'(cmd_raw);
    assign cmd_full     = (cmd_count == CCW'(CMD_DEPTH));
    assign almost_full  = (word_count >= WCW'(DATA_DEPTH - AF_MARGIN));
    assign almost_empty = (word_count <= WCW'(AE_LEVEL));

    txq_unpacker u_unpacker (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .cmd_avail(!cmd_empty), .cmd(cmd),
        .word_avail(!data_empty), .word(word),
        .mac_ready(mac_ready),
        .cmd_pop(cmd_pop), .word_pop(word_pop),
        .mac_valid(mac_valid), .mac_byte(mac_byte),
        .mac_sof(mac_sof), .mac_eof(mac_eof), .pkt_sent(pkt_sent)
    );

    assert_flush_empties_R12: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (word_count == '0 && !mac_valid));
endmodule

// File: tb/txq_top_bench.sv
module txq_top_bench;
    localparam int DD = 32, CD = 4, AFM = 8, AEL = 8;

    logic        clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
    logic        wr_data_valid = 1'b0, wr_cmd_valid = 1'b0, mac_ready = 1'b0;
    logic [31:0] wr_data = '0;
    logic [17:0] wr_cmd = '0;
    logic [5:0]  word_count;
    logic        almost_full, almost_empty, cmd_full;
    logic        mac_valid, mac_sof, mac_eof, pkt_sent;
    logic [7:0]  mac_byte;

    int   n_checks = 0, n_fail = 0;
    bit   done = 1'b0, sent_due = 1'b0;
    logic [9:0] exp_q[$];

    always #5 clk = ~clk;

    txq_top #(.DATA_DEPTH(DD), .CMD_DEPTH(CD), .AF_MARGIN(AFM), .AE_LEVEL(AEL)) u_txq_top (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_data_valid(wr_data_valid), .wr_data(wr_data),
        .wr_cmd_valid(wr_cmd_valid), .wr_cmd(wr_cmd),
        .word_count(word_count), .almost_full(almost_full),
        .almost_empty(almost_empty), .cmd_full(cmd_full),
        .mac_ready(mac_ready), .mac_valid(mac_valid), .mac_byte(mac_byte),
        .mac_sof(mac_sof), .mac_eof(mac_eof), .pkt_sent(pkt_sent)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (sent_due) chk(pkt_sent === 1'b1, "R9 pkt_sent after last byte", pkt_sent, 1);
            else if (pkt_sent) chk(1'b0, "R9 stray pkt_sent", 1, 0);
            sent_due = 1'b0;
            if (mac_valid && mac_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 byte without queued frame", int'(mac_byte), -1);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    chk(mac_byte == e[7:0], "R6 byte value", mac_byte, e[7:0]);
                    chk({mac_sof, mac_eof} == e[9:8], "R7 sof/eof markers",
                        {mac_sof, mac_eof}, e[9:8]);
                end
                if (mac_eof) sent_due = 1'b1;
            end
        end
    end

    task automatic push_words(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            wr_data_valid = 1'b1;
            wr_data = 32'(base + i);
        end
        @(posedge clk); #1;
        wr_data_valid = 1'b0;
    endtask

    task automatic send_frame(input int len, input int lane, input int seed);
        int nw;
        nw = (len + lane + 3) / 4;
        for (int w = 0; w < nw; w++) begin
            logic [31:0] word;
            for (int k = 0; k < 4; k++) begin
                int idx;
                idx = w * 4 + k - lane;
                if (idx >= 0 && idx < len) begin
                    word[8*k +: 8] = 8'(seed + idx * 7);
                    exp_q.push_back({(idx == 0), (idx == len - 1), 8'(seed + idx * 7)});
                end else begin
                    word[8*k +: 8] = 8'hEE;
                end
            end
            @(posedge clk); #1;
            wr_data_valid = 1'b1;
            wr_data = word;
        end
        @(posedge clk); #1;
        wr_data_valid = 1'b0;
        wr_cmd_valid = 1'b1;
        wr_cmd = {2'(lane), 16'(len)};
        @(posedge clk); #1;
        wr_cmd_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    task automatic do_flush(input bit with_write);
        @(posedge clk); #1;
        flush = 1'b1;
        wr_data_valid = with_write;
        wr_data = 32'hDEAD_BEEF;
        @(posedge clk); #1;
        flush = 1'b0;
        wr_data_valid = 1'b0;
        exp_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(word_count == 0, "R1 word_count", word_count, 0);
        chk(almost_empty == 1, "R1 almost_empty", almost_empty, 1);
        chk(almost_full == 0, "R1 almost_full", almost_full, 0);
        chk(cmd_full == 0, "R1 cmd_full", cmd_full, 0);
        chk(mac_valid == 0 && pkt_sent == 0, "R1 mac idle", mac_valid, 0);

        // R2 / R4 / R5: data without command, threshold at 8
        mac_ready = 1'b1;
        push_words(8, 100);
        @(negedge clk);
        chk(word_count == 8, "R2 count after 8", word_count, 8);
        chk(almost_empty == 1, "R4 almost_empty at 8", almost_empty, 1);
        push_words(1, 200);
        @(negedge clk);
        chk(almost_empty == 0, "R4 almost_empty at 9", almost_empty, 0);
        repeat (4) @(negedge clk);
        chk(mac_valid == 0, "R5 no byte without command", mac_valid, 0);
        // R3 threshold at 24
        push_words(14, 300);
        @(negedge clk);
        chk(word_count == 23, "R2 count after 23", word_count, 23);
        chk(almost_full == 0, "R3 almost_full at 23", almost_full, 0);
        push_words(1, 400);
        @(negedge clk);
        chk(almost_full == 1, "R3 almost_full at 24", almost_full, 1);
        push_words(8, 500);
        push_words(1, 600);
        @(negedge clk);
        chk(word_count == 32, "R2 write past full ignored", word_count, 32);

        // R12 flush with concurrent write
        do_flush(1'b1);
        @(negedge clk);
        chk(word_count == 0, "R12 flush empties data", word_count, 0);
        chk(almost_empty == 1, "R12 almost_empty after flush", almost_empty, 1);

        // R6 R7 R8 R9 frames at all lanes
        send_frame(1, 0, 8'h10);
        send_frame(1, 3, 8'h20);
        send_frame(5, 1, 8'h30);
        drain();
        send_frame(8, 0, 8'h40);
        send_frame(7, 3, 8'h50);
        send_frame(13, 2, 8'h60);
        drain();
        @(negedge clk);
        chk(word_count == 0, "R8 all frame words consumed", word_count, 0);

        // R11 zero-length command
        send_frame(0, 2, 8'h00);
        send_frame(3, 0, 8'h70);
        drain();
        @(negedge clk);
        chk(word_count == 0, "R11 zero-length word consumed", word_count, 0);

        // R10 backpressure
        mac_ready = 1'b0;
        send_frame(6, 1, 8'h80);
        repeat (2) @(negedge clk);
        chk(mac_valid == 1, "R10 byte presented", mac_valid, 1);
        begin
            logic [7:0] held;
            held = mac_byte;
            repeat (3) @(negedge clk);
            chk(mac_valid == 1 && mac_byte == held && mac_sof == 1, "R10 held under stall",
                mac_byte, held);
        end
        mac_ready = 1'b1;
        drain();

        // R12 flush abandons a frame in progress
        mac_ready = 1'b0;
        send_frame(9, 2, 8'h90);
        repeat (2) @(negedge clk);
        do_flush(1'b0);
        mac_ready = 1'b1;
        @(negedge clk);
        chk(mac_valid == 0, "R12 frame abandoned", mac_valid, 0);
        chk(word_count == 0, "R12 count zero after abort", word_count, 0);
        repeat (4) @(negedge clk);
        chk(mac_valid == 0, "R12 no command left", mac_valid, 0);

        // Queue still works after flush
        send_frame(4, 1, 8'hA0);
        drain();
        chk(exp_q.size() == 0, "R6 frame after flush delivered", exp_q.size(), 0);

        summary();
    end
endmodule